// File: doc/BRIEF.md
# Multiplexed Pixel Input Demultiplexer

This block sits at the pixel input of a video encoder. Pixel data arrives on an 8-bit bus, one word per cycle in which `din_vld` is high. Each pixel takes two words. The block pairs these words and extracts the colour fields. It then presents one complete pixel on three 8-bit component outputs, together with a one-cycle `pix_vld` pulse.

A 4-bit format code selects the input layout:
- RGB 5-6-5, split over two bytes.
- RGB 5-5-5, split over two bytes.
- An interleaved YCbCr 4:2:2 byte stream.

In both RGB layouts the green component is split across the two words. Components narrower than 8 bits are widened by copying their top bits into the low bits. In YCbCr mode one Cb/Cr pair serves two luma samples, and a pixel is produced for every luma byte.

Each line starts with a single-cycle horizontal sync pulse. A programmable start-of-active-video count, measured in pixels, says how many pixel slots after sync are skipped before capture begins. Word pairing is re-aligned on every line and whenever the format changes.

Top module: `pix_demux`

## Requirements
- R1: While `rst` is high and in the cycle after it, `pix_vld` is 0 and `pix_c0`, `pix_c1` and `pix_c2` are all 0.
- R2: With `fmt_sel` = 0 (RGB 5-6-5), pairing works as follows:
  - The first word holds G[2:0] in bits 7:5 and B[4:0] in bits 4:0.
  - The second word holds R[4:0] in bits 7:3 and G[5:3] in bits 2:0.
  - The outputs are `pix_c0` = R, `pix_c1` = G and `pix_c2` = B.
- R3: With `fmt_sel` = 1 (RGB 5-5-5), pairing works as follows:
  - The first word holds G[2:0] in bits 7:5 and B[4:0] in bits 4:0.
  - The second word holds R[4:0] in bits 6:2 and G[4:3] in bits 1:0.
  - Bit 7 of the second word has no effect on any output.
- R4: Components are widened to 8 bits by MSB replication:
  - a 5-bit value x becomes {x, x[4:2]};
  - a 6-bit value x becomes {x, x[5:4]}.
- R5: With `fmt_sel` = 2 (YCbCr), captured bytes repeat in the order Cb, Y, Cr, Y.
  - Each Y byte produces a pixel with `pix_c0` = Y, `pix_c1` = the latest Cb and `pix_c2` = the latest Cr.
  - Chroma is held across lines.
  - Held chroma resets to 8'h80.
- R6: `pix_vld` is high for exactly one cycle, the cycle after the edge that captures the word completing a pixel. It is never high in two consecutive cycles. The component outputs hold their values while `pix_vld` is low.
- R7: After each horizontal sync, the first 2×`sav_cnt` words with `din_vld` high are discarded. With `sav_cnt` = 0, capture starts at the first word.
- R8: A high `hsync` returns word pairing to the first word of a pixel. Any word presented in the same cycle as `hsync` is discarded.
- R9: A change of `fmt_sel` has the following effects:
  - a half-received pixel is discarded and pairing restarts at the first word;
  - any word presented in the change cycle is discarded;
  - held chroma returns to 8'h80.
- R10: Format codes 3 to 15 never produce a pixel.
- R11: A bus word is taken only in a cycle with `din_vld` high. Any number of idle cycles between the two words of a pixel does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 4 | Input format code (0: RGB 5-6-5, 1: RGB 5-5-5, 2: YCbCr 4:2:2) |
| sav_cnt | input | 9 | Pixel slots skipped after horizontal sync |
| hsync | input | 1 | Single-cycle line start pulse |
| din | input | 8 | Multiplexed pixel bus word |
| din_vld | input | 1 | Word strobe for `din` |
| pix_c0 | output | 8 | Red, or Y |
| pix_c1 | output | 8 | Green, or Cb |
| pix_c2 | output | 8 | Blue, or Cr |
| pix_vld | output | 1 | One-cycle pulse per rebuilt pixel |

## Verification
The bench drives the corner cases below and names what a wrong design would do in each:
- **Fields split across words.** Green is split over both words, and bit patterns put ones at each field edge. A design that shifts a field by one bit, or swaps the word order, returns wrong red and green. A design that reads bit 7 of the second 5-5-5 word shows it in red.
- **Blanking words at a line start.** Two blanking words precede a YCbCr line. A gate off by one word would emit a pixel from blanking bytes, or take Cb as luma and rotate the whole line.
- **A half pixel cut off.** A half pixel is interrupted once by sync and once by a format change. A design without re-alignment would pair the wrong words, producing a bogus pixel and leaving the rest of the line misaligned.
- **Chroma after a format change.** Returning to YCbCr must show the reset chroma value rather than stale chroma.
- **Unused format codes.** Codes 3 to 15 must stay silent.

// File: rtl/pix_demux_pkg.sv
package pix_demux_pkg;

  localparam int CW = 8;

  localparam logic [3:0] FMT_RGB565 = 4'd0;
  localparam logic [3:0] FMT_RGB555 = 4'd1;
  localparam logic [3:0] FMT_YCC422 = 4'd2;

  localparam logic [CW-1:0] CHROMA_MID = 8'h80;

  typedef struct packed {
    logic [CW-1:0] c0;
    logic [CW-1:0] c1;
    logic [CW-1:0] c2;
  } pix_t;

  function automatic logic [CW-1:0] widen5(input logic [4:0] x);
    return {x, x[4:2]};
  endfunction

  function automatic logic [CW-1:0] widen6(input logic [5:0] x);
    return {x, x[5:4]};
  endfunction

  function automatic logic fmt_known(input logic [3:0] f);
    return (f == FMT_RGB565) || (f == FMT_RGB555) || (f == FMT_YCC422);
  endfunction

endpackage

// File: rtl/pix_sav_gate.sv
module pix_sav_gate #(
  parameter int SAV_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsync,
  input  logic             word_vld,
  input  logic [SAV_W-1:0] sav_cnt,
  output logic             take
);
  localparam int WC_W = SAV_W + 1;

  logic [WC_W-1:0] wc_q;
  logic            active_q;
  logic [WC_W-1:0] skip_words;
  logic [WC_W-1:0] wc_inc;

  assign skip_words = {sav_cnt, 1'b0};
  assign wc_inc     = wc_q + 1'b1;
  assign take       = word_vld && active_q && !hsync;

  always_ff @(posedge clk) begin
    if (rst) begin
      wc_q     <= '0;
      active_q <= 1'b0;
    end else if (hsync) begin
      wc_q     <= '0;
      active_q <= (sav_cnt == '0);
    end else if (word_vld && !active_q) begin
      wc_q <= wc_inc;
      if (wc_inc == skip_words) active_q <= 1'b1;
    end
  end

endmodule

// File: rtl/pix_word_pair.sv
module pix_word_pair
  import pix_demux_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          line_clr,
  input  logic          fmt_clr,
  input  logic          take,
  input  logic [3:0]    fmt,
  input  logic [CW-1:0] din,
  output pix_t          pix_nxt,
  output logic          done
);
  logic [1:0]    phase_q;
  logic [CW-1:0] w0_q;
  logic [CW-1:0] cb_q;
  logic [CW-1:0] cr_q;
  logic          is_rgb;
  logic          is_ycc;

  assign is_rgb = (fmt == FMT_RGB565) || (fmt == FMT_RGB555);
  assign is_ycc = (fmt == FMT_YCC422);

  always_comb begin
    done    = 1'b0;
    pix_nxt = '{c0: din, c1: cb_q, c2: cr_q};
    if (take) begin
      if (fmt == FMT_RGB565 && phase_q[0]) begin
        done    = 1'b1;
        pix_nxt = '{c0: widen5(din[7:3]),
                    c1: widen6({din[2:0], w0_q[7:5]}),
                    c2: widen5(w0_q[4:0])};
      end else if (fmt == FMT_RGB555 && phase_q[0]) begin
        done    = 1'b1;
        pix_nxt = '{c0: widen5(din[6:2]),
                    c1: widen5({din[1:0], w0_q[7:5]}),
                    c2: widen5(w0_q[4:0])};
      end else if (is_ycc && phase_q[0]) begin
        done    = 1'b1;
        pix_nxt = '{c0: din, c1: cb_q, c2: cr_q};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || fmt_clr) begin
      phase_q <= '0;
      w0_q    <= '0;
      cb_q    <= CHROMA_MID;
      cr_q    <= CHROMA_MID;
    end else if (line_clr) begin
      phase_q <= '0;
    end else if (take) begin
      if (is_rgb) begin
        phase_q <= {1'b0, ~phase_q[0]};
        if (!phase_q[0]) w0_q <= din;
      end else if (is_ycc) begin
        phase_q <= phase_q + 2'd1;
        if (phase_q == 2'd0) cb_q <= din;
        if (phase_q == 2'd2) cr_q <= din;
      end
    end
  end

endmodule

// File: rtl/pix_demux.sv
module pix_demux
  import pix_demux_pkg::*;
#(
  parameter int SAV_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       fmt_sel,
  input  logic [SAV_W-1:0] sav_cnt,
  input  logic             hsync,
  input  logic [7:0]       din,
  input  logic             din_vld,
  output logic [7:0]       pix_c0,
  output logic [7:0]       pix_c1,
  output logic [7:0]       pix_c2,
  output logic             pix_vld
);
  logic [3:0] fmt_q;
  logic       fmt_chg;
  logic       gate_take;
  logic       take_eff;
  pix_t       pix_nxt;
  logic       pair_done;

  always_ff @(posedge clk) fmt_q <= fmt_sel;

  assign fmt_chg  = (fmt_sel != fmt_q);
  assign take_eff = gate_take && !fmt_chg && fmt_known(fmt_sel);

  pix_sav_gate #(.SAV_W(SAV_W)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .hsync    (hsync),
    .word_vld (din_vld),
    .sav_cnt  (sav_cnt),
    .take     (gate_take)
  );

  pix_word_pair u_pair (
    .clk      (clk),
    .rst      (rst),
    .line_clr (hsync),
    .fmt_clr  (fmt_chg),
    .take     (take_eff),
    .fmt      (fmt_sel),
    .din      (din),
    .pix_nxt  (pix_nxt),
    .done     (pair_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_c0  <= '0;
      pix_c1  <= '0;
      pix_c2  <= '0;
      pix_vld <= 1'b0;
    end else begin
      pix_vld <= pair_done;
      if (pair_done) begin
        pix_c0 <= pix_nxt.c0;
        pix_c1 <= pix_nxt.c1;
        pix_c2 <= pix_nxt.c2;
      end
    end
  end

endmodule

// File: rtl/pix_demux_chk.sv
module pix_demux_chk #(
  parameter int SAV_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       fmt_sel,
  input logic [SAV_W-1:0] sav_cnt,
  input logic             hsync,
  input logic             din_vld,
  input logic [7:0]       pix_c0,
  input logic [7:0]       pix_c1,
  input logic [7:0]       pix_c2,
  input logic             pix_vld
);
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    pix_vld |=> !pix_vld);

  p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !pix_vld |-> ($stable(pix_c0) && $stable(pix_c1) && $stable(pix_c2)));

  p_needs_word_r11: assert property (@(posedge clk) disable iff (rst)
    pix_vld |-> $past(din_vld));

  p_sync_discard_r8: assert property (@(posedge clk) disable iff (rst)
    hsync |=> !pix_vld);

  p_fmt_change_discard_r9: assert property (@(posedge clk) disable iff (rst)
    (fmt_sel != $past(fmt_sel)) |=> !pix_vld);

  p_unknown_fmt_silent_r10: assert property (@(posedge clk) disable iff (rst)
    pix_vld |-> ($past(fmt_sel) <= 4'd2));

endmodule

bind pix_demux pix_demux_chk #(.SAV_W(SAV_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .fmt_sel (fmt_sel),
  .sav_cnt (sav_cnt),
  .hsync   (hsync),
  .din_vld (din_vld),
  .pix_c0  (pix_c0),
  .pix_c1  (pix_c1),
  .pix_c2  (pix_c2),
  .pix_vld (pix_vld)
);

// File: tb/pix_demux_tb_top.sv
module pix_demux_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] fmt_sel = 4'd0;
  logic [8:0] sav_cnt = 9'd0;
  logic       hsync = 1'b0;
  logic [7:0] din = 8'h00;
  logic       din_vld = 1'b0;
  logic [7:0] pix_c0, pix_c1, pix_c2;
  logic       pix_vld;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pix_demux dut_i (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .sav_cnt(sav_cnt),
    .hsync(hsync), .din(din), .din_vld(din_vld),
    .pix_c0(pix_c0), .pix_c1(pix_c1), .pix_c2(pix_c2), .pix_vld(pix_vld)
  );

  // {fmt, word0, word1, exp_c0, exp_c1, exp_c2}
  localparam logic [43:0] VEC [5] = '{
    {4'd0, 8'hE5, 8'hA9, 8'hAD, 8'h3C, 8'h29},  // R2 R4 split green
    {4'd0, 8'h00, 8'hFF, 8'hFF, 8'hE3, 8'h00},  // R2 R4 ones in second word
    {4'd1, 8'h3F, 8'hFA, 8'hF7, 8'h8C, 8'hFF},  // R3 R4
    {4'd1, 8'h00, 8'h80, 8'h00, 8'h00, 8'h00},  // R3 bit 7 ignored
    {4'd1, 8'hE0, 8'h7C, 8'hFF, 8'h39, 8'h00}   // R3 R4
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_pix(input string req, input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    chk(req, {7'd0, pix_vld, pix_c0, pix_c1, pix_c2}, {7'd0, 1'b1, a, b, c});
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    din = b; din_vld = 1'b1;
    @(negedge clk);
    din_vld = 1'b0;
  endtask

  task automatic line_start();
    @(negedge clk);
    hsync = 1'b1;
    @(negedge clk);
    hsync = 1'b0;
  endtask

  task automatic set_fmt(input logic [3:0] f);
    @(negedge clk);
    fmt_sel = f;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {pix_vld, pix_c0, pix_c1, pix_c2}, 25'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {pix_vld, pix_c0, pix_c1, pix_c2}, 25'd0);

    // table walk
    for (int i = 0; i < 5; i++) begin
      logic [43:0] v;
      v = VEC[i];
      if (fmt_sel != v[43:40]) set_fmt(v[43:40]);
      line_start();
      put(v[39:32]);
      chk("R6 no pixel after first word", {31'd0, pix_vld}, 32'd0);
      put(v[31:24]);
      chk_pix(i < 2 ? "R2 R4 565 vector" : "R3 R4 555 vector", v[23:16], v[15:8], v[7:0]);
      @(negedge clk);
      chk("R6 single pulse", {31'd0, pix_vld}, 32'd0);
      chk("R6 hold", {pix_c0, pix_c1, pix_c2}, {8'd0, v[23:0]});
    end

    // R11: long gap between words
    set_fmt(4'd0);
    line_start();
    put(8'hE5);
    repeat (7) @(negedge clk);
    put(8'hA9);
    chk_pix("R11 gap between words", 8'hAD, 8'h3C, 8'h29);

    // R8: hsync cuts a half pixel, word in sync cycle discarded
    put(8'hFF);
    @(negedge clk);
    hsync = 1'b1; din = 8'h55; din_vld = 1'b1;
    @(negedge clk);
    hsync = 1'b0; din_vld = 1'b0;
    chk("R8 no pixel at sync", {31'd0, pix_vld}, 32'd0);
    put(8'h00);
    chk("R8 realigned first word", {31'd0, pix_vld}, 32'd0);
    put(8'hFF);
    chk_pix("R8 realigned pair", 8'hFF, 8'hE3, 8'h00);

    // R9: format change mid pixel, word in change cycle discarded
    put(8'hE5);
    @(negedge clk);
    fmt_sel = 4'd1; din = 8'hA9; din_vld = 1'b1;
    @(negedge clk);
    din_vld = 1'b0;
    chk("R9 no pixel on change", {31'd0, pix_vld}, 32'd0);
    put(8'h3F);
    chk("R9 restart first word", {31'd0, pix_vld}, 32'd0);
    put(8'hFA);
    chk_pix("R9 pair after change", 8'hF7, 8'h8C, 8'hFF);

    // R5 R7: YCbCr with two blanking words
    set_fmt(4'd2);
    sav_cnt = 9'd1;
    line_start();
    put(8'h11);
    put(8'h22);
    chk("R7 blanking discarded", {31'd0, pix_vld}, 32'd0);
    put(8'h40);
    chk("R7 Cb is not a pixel", {31'd0, pix_vld}, 32'd0);
    put(8'h50);
    chk_pix("R5 Y0 with reset Cr", 8'h50, 8'h40, 8'h80);
    put(8'h60);
    put(8'h70);
    chk_pix("R5 Y1 with new Cr", 8'h70, 8'h40, 8'h60);
    put(8'h41);
    put(8'h52);
    chk_pix("R5 next Y0 keeps Cr", 8'h52, 8'h41, 8'h60);

    // R5: chroma held across lines
    line_start();
    put(8'h01); put(8'h02);
    put(8'h33); put(8'h44);
    chk_pix("R5 chroma across line", 8'h44, 8'h33, 8'h60);

    // R9: chroma reset after leaving and re-entering YCbCr
    set_fmt(4'd0);
    set_fmt(4'd2);
    sav_cnt = 9'd0;
    line_start();
    put(8'h90); put(8'hA0);
    chk_pix("R9 chroma reset", 8'hA0, 8'h90, 8'h80);

    // R10: unused format codes
    set_fmt(4'd5);
    line_start();
    for (int k = 0; k < 4; k++) begin
      put(8'hC3 + 8'(k));
      chk("R10 unknown fmt silent", {31'd0, pix_vld}, 32'd0);
    end
    set_fmt(4'd15);
    put(8'h12); put(8'h34);
    chk("R10 fmt 15 silent", {31'd0, pix_vld}, 32'd0);

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 reset again", {pix_vld, pix_c0, pix_c1, pix_c2}, 25'd0);
    rst = 1'b0;

    finish_run();
  end

endmodule